// File: doc/BRIEF.md
# SAR ADC Parallel-Bus Host Controller

This block sits next to a 14-bit successive-approximation converter and runs it on the host's behalf. The converter has a chip-select and a read/convert strobe and a 14-bit parallel output. Each conversion uses three chip-select low pulses. The first pulse's falling edge, taken with read/convert low, opens the acquisition window. The second pulse's falling edge closes that window and starts the conversion. After the converter's end-of-conversion line falls, a third low pulse enables the converter's output bus so that the word can be captured.

The read/convert level at the second falling edge picks what the converter does after it finishes. Low keeps the reference powered (standby). High switches the reference and its buffer off (shutdown). The controller tracks the mode of the last conversion. After a shutdown, and after a reset, it waits a configurable number of clocks for the reference to settle before the next acquisition. If end-of-conversion does not fall within a configurable window, the controller abandons the conversion and flags it. After its own reset, the controller pulses the converter's reset line with chip-select held high.

The host gives a one-cycle start request together with a low-power select bit. It receives a registered result word and a one-cycle valid strobe. A request that arrives while the controller is busy is kept and served when the controller is free again.

Top module: `sar_host_ctrl`

## Requirements
- R1: While `rst_n` is low and for `RST_CYC` cycles after it rises, `adc_rst_o` is 1, `adc_cs_n_o` is 1 and `result_vld_o` is 0. Afterwards `adc_rst_o` is 0.
- R2: Acquisition opens on a chip-select falling edge with `adc_rc_o` = 0. Chip-select stays low for `CSL_CYC` cycles and then returns high. The next falling edge comes at least `ACQ_CYC` cycles after the first one.
- R3: At the second falling edge, `adc_rc_o` equals the `lowpwr_i` value accepted with the request: 1 selects shutdown and 0 selects standby. `adc_rc_o` does not change while chip-select is low.
- R4: The controller waits for a falling edge of `adc_eoc_n_i`, including one that happens during the second low pulse. It then holds chip-select high for `CSH_CYC` cycles and drives it low to read. No read edge is issued before end-of-conversion falls.
- R5: `adc_data_i` is sampled `DV_CYC` cycles after the read falling edge. It appears on `result_o` with `result_vld_o` high for exactly one cycle.
- R6: If end-of-conversion has not fallen `EOC_TMO_CYC` cycles after the second falling edge, `timeout_o` pulses for one cycle. In that case there is no read edge and no `result_vld_o`, and the controller becomes idle again.
- R7: After reset, or after a conversion in shutdown mode, at least `SETTLE_CYC` cycles separate the accepted request from the first falling edge. After a conversion in standby mode, the first edge follows the request on the next cycle.
- R8: A `start_i` pulse that arrives while a conversion is in progress is kept. It starts one more conversion once the current one is finished.
- R9: Between any two chip-select low pulses, chip-select stays high for at least `CSH_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle conversion request |
| lowpwr_i | input | 1 | Power mode after conversion: 1 shutdown, 0 standby |
| adc_eoc_n_i | input | 1 | End-of-conversion from the converter, active low, asynchronous |
| adc_data_i | input | DATA_W | Converter output bus |
| adc_cs_n_o | output | 1 | Chip-select to the converter, active low |
| adc_rc_o | output | 1 | Read/convert strobe to the converter |
| adc_rst_o | output | 1 | Reset line to the converter |
| result_o | output | DATA_W | Last captured conversion word |
| result_vld_o | output | 1 | One-cycle strobe when `result_o` is updated |
| timeout_o | output | 1 | One-cycle strobe when a conversion is abandoned |

## Verification
The bench drives conversions with an all-ones word, an all-zeros word and mixed-bit words. These show whether every bus bit is captured and whether the bus was sampled only after the data-valid delay, since the bus carries a filler pattern until then. Runs alternate standby and shutdown. The measured request-to-first-edge gap then shows whether the settle wait follows the previous conversion's mode and not the current one. End-of-conversion is made to fall early, inside the second low pulse, late, or never. These cases separate a latched early edge from a missed one, and a completed read from a timeout. A second request sent mid-conversion shows whether pending requests are kept.

// File: rtl/sar_host_pkg.sv
`timescale 1ns/1ps
package sar_host_pkg;

   typedef enum logic [3:0] {
      ST_RST,
      ST_IDLE,
      ST_SETTLE,
      ST_ACQL,
      ST_ACQH,
      ST_CONVL,
      ST_WAIT,
      ST_RDGAP,
      ST_READ,
      ST_POST
   } ctl_st_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sar_host_sync.sv
`timescale 1ns/1ps
module sar_host_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sar_host_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= RST_VAL;
            else        ff_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= {STAGES{RST_VAL}};
            else        ff_q <= {ff_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/sar_host_timer.sv
`timescale 1ns/1ps
module sar_host_timer #(
   parameter int           W    = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         done_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= INIT;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sar_host_ctrl.sv
`timescale 1ns/1ps
module sar_host_ctrl
   import sar_host_pkg::*;
#(
   parameter int DATA_W      = 14,
   parameter int CSL_CYC     = 3,
   parameter int CSH_CYC     = 3,
   parameter int ACQ_CYC     = 16,
   parameter int DV_CYC      = 3,
   parameter int EOC_TMO_CYC = 600,
   parameter int SETTLE_CYC  = 750000,
   parameter int RST_CYC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              lowpwr_i,
   input  logic              adc_eoc_n_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic              adc_cs_n_o,
   output logic              adc_rc_o,
   output logic              adc_rst_o,
   output logic [DATA_W-1:0] result_o,
   output logic              result_vld_o,
   output logic              timeout_o
);

   localparam int ACQH_CYC = int'(umax(int'(ACQ_CYC - CSL_CYC), CSH_CYC));
   localparam int WAIT_CYC = EOC_TMO_CYC - CSL_CYC;
   localparam int MAX_CYC  = int'(umax(umax(umax(SETTLE_CYC, WAIT_CYC), umax(ACQH_CYC, DV_CYC)),
                                       umax(umax(CSL_CYC, CSH_CYC), RST_CYC)));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   generate
      if (DATA_W < 1)                  begin : g_bad_w    $error("DATA_W must be positive"); end
      if (CSL_CYC < 1 || CSH_CYC < 1)  begin : g_bad_cs   $error("chip-select times must be positive"); end
      if (ACQ_CYC <= CSL_CYC)          begin : g_bad_acq  $error("ACQ_CYC must exceed CSL_CYC"); end
      if (DV_CYC < 1)                  begin : g_bad_dv   $error("DV_CYC must be positive"); end
      if (EOC_TMO_CYC <= CSL_CYC)      begin : g_bad_tmo  $error("EOC_TMO_CYC must exceed CSL_CYC"); end
      if (SETTLE_CYC < 1 || RST_CYC < 1) begin : g_bad_st $error("settle and reset times must be positive"); end
   endgenerate

   ctl_st_e           st_q, st_d;
   logic              tdone, tload;
   logic [CNT_W-1:0]  tval;
   logic              eoc_s, eoc_d_q, eoc_fall, eoc_hit_q, eoc_seen;
   logic              mode_q, shut_q, pend_q, go;
   logic              cap, tmo_d;
   logic              cs_n_q, rc_q, rst_q, vld_q, tmo_q;
   logic [DATA_W-1:0] res_q;

   function automatic logic [CNT_W-1:0] dur_m1(input ctl_st_e s);
      case (s)
         ST_RST:    return CNT_W'(RST_CYC - 1);
         ST_SETTLE: return CNT_W'(SETTLE_CYC - 1);
         ST_ACQL:   return CNT_W'(CSL_CYC - 1);
         ST_ACQH:   return CNT_W'(ACQH_CYC - 1);
         ST_CONVL:  return CNT_W'(CSL_CYC - 1);
         ST_WAIT:   return CNT_W'(WAIT_CYC - 1);
         ST_RDGAP:  return CNT_W'(CSH_CYC - 1);
         ST_READ:   return CNT_W'(DV_CYC - 1);
         ST_POST:   return CNT_W'(CSH_CYC - 1);
         default:   return '0;
      endcase
   endfunction

   sar_host_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_eoc_sync (
      .clk(clk), .rst_n(rst_n), .d_i(adc_eoc_n_i), .q_o(eoc_s)
   );

   sar_host_timer #(.W(CNT_W), .INIT(CNT_W'(RST_CYC - 1))) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tload), .val_i(tval), .done_o(tdone)
   );

   assign eoc_fall = eoc_d_q & ~eoc_s;
   assign eoc_seen = eoc_hit_q | eoc_fall;
   assign go       = start_i | pend_q;

   always_comb begin
      st_d  = st_q;
      cap   = 1'b0;
      tmo_d = 1'b0;
      case (st_q)
         ST_RST:    if (tdone) st_d = ST_IDLE;
         ST_IDLE:   if (go)    st_d = shut_q ? ST_SETTLE : ST_ACQL;
         ST_SETTLE: if (tdone) st_d = ST_ACQL;
         ST_ACQL:   if (tdone) st_d = ST_ACQH;
         ST_ACQH:   if (tdone) st_d = ST_CONVL;
         ST_CONVL:  if (tdone) st_d = ST_WAIT;
         ST_WAIT: begin
            if (eoc_seen)   st_d = ST_RDGAP;
            else if (tdone) begin
               st_d  = ST_POST;
               tmo_d = 1'b1;
            end
         end
         ST_RDGAP:  if (tdone) st_d = ST_READ;
         ST_READ: begin
            if (tdone) begin
               st_d = ST_POST;
               cap  = 1'b1;
            end
         end
         ST_POST:   if (tdone) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   assign tload = (st_d != st_q);
   assign tval  = dur_m1(st_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_RST;
         eoc_d_q   <= 1'b1;
         eoc_hit_q <= 1'b0;
         mode_q    <= 1'b0;
         shut_q    <= 1'b1;
         pend_q    <= 1'b0;
         cs_n_q    <= 1'b1;
         rc_q      <= 1'b0;
         rst_q     <= 1'b1;
         vld_q     <= 1'b0;
         tmo_q     <= 1'b0;
         res_q     <= '0;
      end else begin
         st_q      <= st_d;
         eoc_d_q   <= eoc_s;
         eoc_hit_q <= (st_q inside {ST_CONVL, ST_WAIT}) ? (eoc_hit_q | eoc_fall) : 1'b0;
         if (st_q == ST_IDLE && go) mode_q <= lowpwr_i;
         if (st_q == ST_ACQH && st_d == ST_CONVL) shut_q <= mode_q;
         if (st_q == ST_IDLE)  pend_q <= 1'b0;
         else if (start_i)     pend_q <= 1'b1;
         cs_n_q    <= !(st_d inside {ST_ACQL, ST_CONVL, ST_READ});
         rc_q      <= (st_d inside {ST_ACQH, ST_CONVL}) & mode_q;
         rst_q     <= (st_d == ST_RST);
         vld_q     <= cap;
         tmo_q     <= tmo_d;
         if (cap) res_q <= adc_data_i;
      end
   end

   assign adc_cs_n_o   = cs_n_q;
   assign adc_rc_o     = rc_q;
   assign adc_rst_o    = rst_q;
   assign result_o     = res_q;
   assign result_vld_o = vld_q;
   assign timeout_o    = tmo_q;

endmodule

// File: rtl/sar_host_ctrl_chk.sv
`timescale 1ns/1ps
module sar_host_ctrl_chk
   import sar_host_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    adc_cs_n_o,
   input logic    adc_rc_o,
   input logic    adc_rst_o,
   input logic    result_vld_o,
   input logic    timeout_o,
   input ctl_st_e st_q,
   input logic    mode_q
);

   // R1
   rst_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_rst_o |-> adc_cs_n_o);

   // R2
   acq_edge_rc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_cs_n_o) && st_q == ST_ACQL) |-> !adc_rc_o);

   // R3
   conv_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_cs_n_o) && st_q == ST_CONVL) |-> (adc_rc_o == mode_q));

   // R3
   rc_steady_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_cs_n_o && $past(!adc_cs_n_o)) |-> $stable(adc_rc_o));

   // R5
   vld_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld_o |=> !result_vld_o);

   // R5
   vld_after_bus_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld_o |-> $past(!adc_cs_n_o));

   // R6
   tmo_excl_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> !result_vld_o);

   // R6
   tmo_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

endmodule

bind sar_host_ctrl sar_host_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .adc_cs_n_o(adc_cs_n_o), .adc_rc_o(adc_rc_o),
   .adc_rst_o(adc_rst_o), .result_vld_o(result_vld_o), .timeout_o(timeout_o),
   .st_q(st_q), .mode_q(mode_q)
);

// File: tb/sar_host_ctrl_bench.sv
`timescale 1ns/1ps
module sar_host_ctrl_bench;

   localparam int DATA_W = 14;
   localparam int CSL    = 3;
   localparam int CSH    = 3;
   localparam int ACQ    = 12;
   localparam int DV     = 3;
   localparam int TMO    = 40;
   localparam int SETTLE = 60;
   localparam int RSTC   = 4;
   localparam logic [DATA_W-1:0] FILL = 14'h2AAA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic lowpwr = 1'b0;
   logic eoc_n;
   logic [DATA_W-1:0] bus;
   logic cs_n, rc, adc_rst, vld, tmo;
   logic [DATA_W-1:0] result;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sar_host_ctrl #(
      .DATA_W(DATA_W), .CSL_CYC(CSL), .CSH_CYC(CSH), .ACQ_CYC(ACQ), .DV_CYC(DV),
      .EOC_TMO_CYC(TMO), .SETTLE_CYC(SETTLE), .RST_CYC(RSTC), .SYNC_STAGES(2)
   ) u_sar_host_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .lowpwr_i(lowpwr),
      .adc_eoc_n_i(eoc_n), .adc_data_i(bus), .adc_cs_n_o(cs_n), .adc_rc_o(rc),
      .adc_rst_o(adc_rst), .result_o(result), .result_vld_o(vld), .timeout_o(tmo)
   );

   // ---------------- converter model ----------------
   int          cyc = 0;
   logic        prev_cs = 1'b1;
   int          phase = 0;
   int          conv_cnt = 0;
   int          conv_dly = 20;
   logic        eoc_m = 1'b1;
   int          rd_cnt = 0;
   int          fall1_cyc = 0, fall2_cyc = 0, acq_len = 0;
   logic        mode_seen = 1'b0;
   int          rc_first_hi = 0;
   int          early_falls = 0;
   int          hi_cnt = 1000, min_hi = 1000;
   logic        model_clr = 1'b0;
   logic [DATA_W-1:0] sample = '0;

   assign eoc_n = eoc_m;
   assign bus   = (phase == 4 && !cs_n && rd_cnt >= DV - 1) ? sample : FILL;

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      prev_cs <= cs_n;
      if (cs_n) hi_cnt <= hi_cnt + 1;
      if (adc_rst || model_clr) begin
         phase <= 0;
         eoc_m <= 1'b1;
      end else begin
         if (prev_cs && !cs_n) begin
            if (hi_cnt < min_hi) min_hi <= hi_cnt;
            hi_cnt <= 0;
            case (phase)
               0: begin
                  if (rc) rc_first_hi <= rc_first_hi + 1;
                  else begin
                     phase     <= 1;
                     fall1_cyc <= cyc;
                  end
               end
               1: begin
                  phase     <= 2;
                  fall2_cyc <= cyc;
                  acq_len   <= cyc - fall1_cyc;
                  mode_seen <= rc;
                  conv_cnt  <= conv_dly;
               end
               3: begin
                  phase  <= 4;
                  rd_cnt <= 1;
               end
               default: early_falls <= early_falls + 1;
            endcase
         end else begin
            if (phase == 2) begin
               if (conv_cnt > 0) conv_cnt <= conv_cnt - 1;
               else if (conv_cnt == 0) begin
                  eoc_m <= 1'b0;
                  phase <= 3;
               end
            end
            if (phase == 4 && !cs_n) rd_cnt <= rd_cnt + 1;
            if (phase == 4 && !prev_cs && cs_n) begin
               phase <= 0;
               eoc_m <= 1'b1;
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   // issue one request and wait for its outcome
   task automatic convert(input logic [DATA_W-1:0] val, input bit lp, input int cdly,
                          input bit exp_settle, input string tag,
                          output bit got_vld, output bit got_tmo, output int tmo_cyc,
                          output int st_cyc);
      @(negedge clk);
      sample   = val;
      conv_dly = cdly;
      lowpwr   = lp;
      start    = 1'b1;
      st_cyc   = cyc;
      @(negedge clk);
      start    = 1'b0;
      got_vld  = 1'b0;
      got_tmo  = 1'b0;
      tmo_cyc  = 0;
      for (int i = 0; i < 2000 && !got_vld && !got_tmo; i++) begin
         if (vld) got_vld = 1'b1;
         if (tmo) begin
            got_tmo = 1'b1;
            tmo_cyc = cyc;
         end
         if (!got_vld && !got_tmo) @(negedge clk);
      end
      if (exp_settle)
         check(fall1_cyc - st_cyc >= SETTLE, "R7", {tag, " settle gap"}, fall1_cyc - st_cyc, SETTLE);
      else
         check(fall1_cyc - st_cyc <= 2, "R7", {tag, " no-settle gap"}, fall1_cyc - st_cyc, 1);
      check(acq_len >= ACQ, "R2", {tag, " acquisition length"}, acq_len, ACQ);
      check(mode_seen == lp, "R3", {tag, " rc at second edge"}, int'(mode_seen), int'(lp));
   endtask

   task automatic expect_result(input logic [DATA_W-1:0] val, input string tag);
      bit v, t;
      int tc, sc;
      convert(val, lowpwr, conv_dly, 1'b0, tag, v, t, tc, sc);
   endtask

   task automatic run_ok(input logic [DATA_W-1:0] val, input bit lp, input int cdly,
                         input bit exp_settle, input string tag);
      bit v, t;
      int tc, sc;
      convert(val, lp, cdly, exp_settle, tag, v, t, tc, sc);
      check(v && !t, "R4", {tag, " conversion completed"}, int'(v), 1);
      check(result == val, "R5", {tag, " result word"}, int'(result), int'(val));
      @(negedge clk);
      check(!vld, "R5", {tag, " valid is one cycle"}, int'(vld), 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(adc_rst == 1'b1, "R1", "reset line high after release", int'(adc_rst), 1);
      check(cs_n == 1'b1, "R1", "cs high during reset pulse", int'(cs_n), 1);
      check(vld == 1'b0, "R1", "no valid during reset", int'(vld), 0);
      repeat (RSTC + 2) @(negedge clk);
      check(adc_rst == 1'b0, "R1", "reset line released", int'(adc_rst), 0);
      check(cs_n == 1'b1, "R1", "cs idle high", int'(cs_n), 1);
   endtask

   task automatic t_timeout;
      bit v, t;
      int tc, sc;
      convert(14'h0F0F, 1'b0, -1, 1'b0, "timeout", v, t, tc, sc);
      check(t && !v, "R6", "timeout flagged, no result", int'(t), 1);
      check(tc - fall2_cyc >= TMO && tc - fall2_cyc <= TMO + 1, "R6", "timeout delay",
            tc - fall2_cyc, TMO);
      @(negedge clk);
      check(!tmo, "R6", "timeout is one cycle", int'(tmo), 0);
      repeat (10) @(negedge clk);
      check(early_falls == 0, "R6", "no read edge after timeout", early_falls, 0);
      model_clr = 1'b1;
      @(negedge clk);
      model_clr = 1'b0;
   endtask

   task automatic t_pending;
      int got = 0;
      @(negedge clk);
      sample   = 14'h1357;
      conv_dly = 15;
      lowpwr   = 1'b0;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      repeat (6) @(negedge clk);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      for (int i = 0; i < 2000 && got < 2; i++) begin
         if (vld) begin
            got++;
            if (got == 1) begin
               check(result == 14'h1357, "R8", "first queued result", int'(result), 'h1357);
               sample = 14'h2468;
            end else begin
               check(result == 14'h2468, "R8", "pending request served", int'(result), 'h2468);
            end
         end
         @(negedge clk);
      end
      check(got == 2, "R8", "two results for two requests", got, 2);
   endtask

   initial begin
      t_reset();
      run_ok(14'h1234, 1'b0, 20, 1'b1, "first after reset");
      run_ok(14'h3FFF, 1'b0, 20, 1'b0, "standby follow-up");
      run_ok(14'h0000, 1'b1, 20, 1'b0, "shutdown request");
      run_ok(14'h2D4B, 1'b0, 25, 1'b1, "after shutdown");
      run_ok(14'h0001, 1'b0, 0, 1'b0, "early end-of-conversion");
      t_timeout();
      run_ok(14'h1555, 1'b0, 20, 1'b0, "after timeout");
      t_pending();
      check(min_hi >= CSH, "R9", "minimum cs high time", min_hi, CSH);
      check(rc_first_hi == 0, "R2", "first edges taken with rc low", rc_first_hi, 0);
      check(early_falls == 0, "R4", "no edge before end-of-conversion", early_falls, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

endmodule